// File: doc/BRIEF.md
# Double-Edge I/Q Transmit Splitter

This block sits between a baseband processor and a pair of transmit DACs. The processor drives one 8-bit bus at twice the clock rate. In-phase and quadrature words alternate on that bus. The block takes the word that is present at each rising clock edge as the in-phase sample and the word present at each falling edge as the quadrature sample. It then presents both as one aligned pair of DAC codes in the rising-edge domain, together with a one-cycle strobe.

The two samples of a pair are half a clock apart. The block does not correct for this. The processor must pre-compensate its samples. An active-low mode input selects between two modes. In dual-channel mode both codes follow the bus. In single-channel (FM) mode only the quadrature code moves and the in-phase code rests at mid-scale. A power-down input forces both codes to full scale, so the positive side of each differential output sits high. A synchronous active-low reset returns everything to mid-scale.

Top module: `txiq_split`

## Requirements
- R1: While `rst_n` is low at a rising edge, `i_code` and `q_code` become 8'h80 and `pair_vld` becomes 0 after that edge.
- R2: The `tx_word` value present at a rising edge of `clk` is the in-phase sample. It appears on `i_code` after the following rising edge.
- R3: The `tx_word` value present at the falling edge between those two rising edges is the quadrature sample. It appears on `q_code` at the same time as the in-phase sample it is paired with.
- R4: Whenever `pd` is low at a rising edge (and reset is inactive), `pair_vld` is 1 after that edge. The I/Q pair shown then is one complete pair.
- R5: In FM mode (`fm_n` = 0), `i_code` is held at 8'h80 and `q_code` still follows the falling-edge sample.
- R6: `fm_n` is sampled at a rising edge. The pair output after the next rising edge is the first one that uses the new mode.
- R7: When `pd` is high at a rising edge, both codes become 8'hFF and `pair_vld` becomes 0 after that edge, in either mode.
- R8: When `pd` is released, the next pair delivers the bus samples again with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock; the bus carries two words per period |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_word | input | 8 | Interleaved I/Q sample bus, bit 7 is MSB |
| fm_n | input | 1 | Mode select, low selects FM (Q only) |
| pd | input | 1 | Power-down, high forces full-scale codes |
| i_code | output | 8 | In-phase DAC code |
| q_code | output | 8 | Quadrature DAC code |
| pair_vld | output | 1 | High for each cycle that delivers a fresh pair |

## Verification
The hardest situation to reach from the ports is the mode switch. The edge where `fm_n` is sampled still delivers a pair under the old mode. The in-phase value there is a word that also reaches the falling-edge register. So the bench holds one word across a falling edge, changes `fm_n` and the bus just after that edge, and then checks two pairs. The first must still carry the held word on `i_code`. The second must show mid-scale on `i_code` and the new word on `q_code`. A swapped edge assignment, or a mode path with no register, shows up as a wrong value in exactly one of those two pairs.

// File: rtl/txiq_split.sv
module txiq_split #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tx_word,
  input  logic         fm_n,
  input  logic         pd,
  output logic [W-1:0] i_code,
  output logic [W-1:0] q_code,
  output logic         pair_vld
);
  localparam logic [W-1:0] MID  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] FULL = {W{1'b1}};

  logic [W-1:0] cap_i, cap_q;
  logic         fm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_i <= MID;
      fm_q  <= 1'b0;
    end else begin
      cap_i <= tx_word;
      fm_q  <= ~fm_n;
    end
  end

  always_ff @(negedge clk) begin
    if (!rst_n) cap_q <= MID;
    else        cap_q <= tx_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_code   <= MID;
      q_code   <= MID;
      pair_vld <= 1'b0;
    end else if (pd) begin
      i_code   <= FULL;
      q_code   <= FULL;
      pair_vld <= 1'b0;
    end else begin
      i_code   <= fm_q ? MID : cap_i;
      q_code   <= cap_q;
      pair_vld <= 1'b1;
    end
  end

  // R1
  reset_mid_chk: assert property (@(posedge clk)
    !rst_n |=> (i_code == MID && q_code == MID && !pair_vld));

  // R7
  pd_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (i_code == FULL && q_code == FULL && !pair_vld));

  // R4
  vld_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd |=> pair_vld);

  // R5
  fm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fm_q && !pd) |=> (i_code == MID));

  // R6
  mode_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fm_n |=> fm_q);
endmodule

// File: tb/txiq_split_tb_top.sv
module txiq_split_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] tx_word = 8'h00;
  logic fm_n = 1'b1;
  logic pd = 1'b0;
  logic [7:0] i_code, q_code;
  logic pair_vld;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  txiq_split dut_i (
    .clk(clk), .rst_n(rst_n), .tx_word(tx_word), .fm_n(fm_n), .pd(pd),
    .i_code(i_code), .q_code(q_code), .pair_vld(pair_vld)
  );

  // {fm_n, pd, i word, q word}
  localparam int NV = 10;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h12, 8'h34},
    {1'b1, 1'b0, 8'hFF, 8'h00},
    {1'b1, 1'b0, 8'h00, 8'hFF},
    {1'b1, 1'b0, 8'hA5, 8'h5A},
    {1'b0, 1'b0, 8'h77, 8'h3C},
    {1'b0, 1'b0, 8'h01, 8'hFE},
    {1'b0, 1'b1, 8'h44, 8'h55},
    {1'b1, 1'b1, 8'h66, 8'h99},
    {1'b1, 1'b0, 8'hC3, 8'h3C},
    {1'b0, 1'b0, 8'h80, 8'h7F}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pair(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk); #1 tx_word = a;
    @(posedge clk); #1 tx_word = b;
    @(posedge clk); #1;
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 i reset", i_code, 8'h80);
    chk("R1 q reset", q_code, 8'h80);
    chk("R1 vld reset", {7'b0, pair_vld}, 8'h00);
    @(negedge clk) rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [7:0] ei, eq, ev;
      @(negedge clk); #1;
      fm_n = VEC[k][17];
      pd   = VEC[k][16];
      tx_word = VEC[k][15:8];
      @(posedge clk); #1 tx_word = VEC[k][7:0];
      @(posedge clk); #1;
      if (VEC[k][16]) begin
        ei = 8'hFF; eq = 8'hFF; ev = 8'h00;   // R7
      end else if (!VEC[k][17]) begin
        ei = 8'h80; eq = VEC[k][7:0]; ev = 8'h01;  // R5
      end else begin
        ei = VEC[k][15:8]; eq = VEC[k][7:0]; ev = 8'h01;  // R2 R3 R8
      end
      chk("R2/R5/R7 i_code", i_code, ei);
      chk("R3/R7 q_code", q_code, eq);
      chk("R4/R7 pair_vld", {7'b0, pair_vld}, ev);
    end

    // R6: mode change latency
    pd = 1'b0; fm_n = 1'b1;
    pair(8'h11, 8'h22);
    chk("R2 pre-switch i", i_code, 8'h11);
    @(negedge clk); #1 fm_n = 1'b0; tx_word = 8'h33;
    @(posedge clk); #1;
    chk("R6 old mode i", i_code, 8'h22);
    chk("R6 old mode q", q_code, 8'h22);
    tx_word = 8'h44;
    @(posedge clk); #1;
    chk("R6 new mode i", i_code, 8'h80);
    chk("R6 new mode q", q_code, 8'h44);

    // R8: release from power-down
    fm_n = 1'b1;
    @(negedge clk); #1 pd = 1'b1;
    @(posedge clk); #1;
    chk("R7 pd i", i_code, 8'hFF);
    pd = 1'b0;
    pair(8'h5E, 8'hE5);
    chk("R8 resume i", i_code, 8'h5E);
    chk("R8 resume q", q_code, 8'hE5);

    // R1: reset mid-run
    fm_n = 1'b0;
    pair(8'h01, 8'h02);
    @(negedge clk); #1 rst_n = 1'b0; fm_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 mid-run i", i_code, 8'h80);
    chk("R1 mid-run q", q_code, 8'h80);
    chk("R1 mid-run vld", {7'b0, pair_vld}, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    pair(8'h9A, 8'hA9);
    chk("R2 after reset i", i_code, 8'h9A);
    chk("R3 after reset q", q_code, 8'hA9);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule